// File: doc/BRIEF.md
# Multi-Channel Conversion Scan Sequencer

This block steps a group of analog measurement channels through one shared converter. A scan is requested with a start pulse; the scan mode selected at that moment fixes which channels are converted and in which order. For each step the sequencer presents a channel code to the converter and pulses a convert-start strobe. It then waits for the converter's done strobe, which carries a 12-bit sample.

Each sample is passed on with a single-cycle valid strobe and a 1-bit class tag. The tag tells the downstream result buffer which half of a coordinate or auxiliary pair the sample belongs to. A busy flag covers the whole scan. Two sticky flags record that an X or a Y sample has been produced since the last status read.

In the auxiliary scan, three enable bits select the channels, and channels whose bit is cleared are skipped. Settling control, panel drive switching and the analog front end are handled elsewhere.

Top module: `scan_sequencer`

## Requirements
- R1: Channel codes on chan_sel_o are X=0, Y=1, Z1=2, Z2=3, BAT=4, AUX1=5, AUX2=6, TEMP=7. While conv_start_o is high, chan_sel_o carries the code of the channel being started.
- R2: Mode 0 converts Y then X. Mode 1 converts Y, X, Z1, Z2. Mode 2 converts Z1 then Z2.
- R3: Mode 3 converts AUX1, AUX2 and TEMP in that order. aux_en_i bit 0 enables AUX1, bit 1 enables AUX2 and bit 2 enables TEMP, and a channel whose bit is 0 is skipped.
- R4: Mode 4 converts BAT, AUX1, AUX2. Modes 5 to 7, and mode 3 with aux_en_i = 0, issue no convert-start and leave busy_o low.
- R5: res_id_o is 0 for X, Z1, BAT and AUX2 samples and 1 for Y, Z2, AUX1 and TEMP samples.
- R6: A done strobe is accepted while busy_o is high, except in a cycle when conv_start_o is high. An accepted strobe gives exactly one res_valid_o pulse in the next cycle, one cycle wide, with res_data_o equal to the sampled conv_data_i. A done strobe while idle gives no result.
- R7: After reset, busy_o, conv_start_o, res_valid_o and both available flags are low. An accepted start raises busy_o and a one-cycle conv_start_o in the next cycle. Each accepted non-final done gives the next conv_start_o in the same cycle as its result. After the final done, busy_o falls in the same cycle as that result.
- R8: A start pulse while busy_o is high is ignored. scan_mode_i and aux_en_i are sampled only on an accepted start.
- R9: x_avail_o and y_avail_o rise with the res_valid_o of an X or a Y sample and hold until status_rd_i is sampled high. When a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Scan request pulse |
| scan_mode_i | input | 3 | Scan mode select |
| aux_en_i | input | 3 | Auxiliary channel enables for mode 3 |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | 12 | Converter sample, valid with conv_done_i |
| status_rd_i | input | 1 | Status read strobe, clears the available flags |
| chan_sel_o | output | 3 | Channel code to the converter |
| conv_start_o | output | 1 | Convert-start strobe |
| res_valid_o | output | 1 | Result valid strobe |
| res_id_o | output | 1 | Result class tag |
| res_data_o | output | 12 | Result sample |
| busy_o | output | 1 | Scan in progress |
| x_avail_o | output | 1 | Sticky X-sample-available flag |
| y_avail_o | output | 1 | Sticky Y-sample-available flag |

## Verification
A status read can arrive on the same edge at which an X or Y result sets its available flag. The clear and the set then meet in one cycle. The bench raises status_rd_i together with conv_done_i on selected conversions, both in directed XY scans and at random. It judges the flags against a bench model that applies the clear first and then the set. A start pulse landing in a busy cycle is the second overlap: it is injected while a conversion is pending, and the bench expects no extra convert-start.

// File: rtl/scan_seq_pkg.sv
// Shared widths, channel codes, mode codes and per-mode ordering rules
// for the conversion scan sequencer.
package scan_seq_pkg;
    localparam int CHAN_W     = 3;
    localparam int NUM_SLOTS  = 4;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int MODE_W     = 3;
    localparam int AUX_N      = 3;

    typedef enum logic [CHAN_W-1:0] {
        CH_X    = 3'd0,
        CH_Y    = 3'd1,
        CH_Z1   = 3'd2,
        CH_Z2   = 3'd3,
        CH_BAT  = 3'd4,
        CH_AUX1 = 3'd5,
        CH_AUX2 = 3'd6,
        CH_TEMP = 3'd7
    } chan_e;

    localparam logic [MODE_W-1:0] MODE_XY   = 3'd0;
    localparam logic [MODE_W-1:0] MODE_XYZZ = 3'd1;
    localparam logic [MODE_W-1:0] MODE_ZZ   = 3'd2;
    localparam logic [MODE_W-1:0] MODE_AUTO = 3'd3;
    localparam logic [MODE_W-1:0] MODE_PORT = 3'd4;

    // Channel held in a given slot of a mode's fixed sequence.
    function automatic chan_e slot_chan(input logic [MODE_W-1:0] mode,
                                        input logic [SLOT_IDX_W-1:0] idx);
        chan_e ch;
        ch = CH_X;
        case (mode)
            MODE_XY, MODE_XYZZ: begin
                case (idx)
                    2'd0:    ch = CH_Y;
                    2'd1:    ch = CH_X;
                    2'd2:    ch = CH_Z1;
                    default: ch = CH_Z2;
                endcase
            end
            MODE_ZZ:   ch = (idx == 2'd0) ? CH_Z1 : CH_Z2;
            MODE_AUTO: begin
                case (idx)
                    2'd0:    ch = CH_AUX1;
                    2'd1:    ch = CH_AUX2;
                    default: ch = CH_TEMP;
                endcase
            end
            MODE_PORT: begin
                case (idx)
                    2'd0:    ch = CH_BAT;
                    2'd1:    ch = CH_AUX1;
                    default: ch = CH_AUX2;
                endcase
            end
            default:   ch = CH_X;
        endcase
        return ch;
    endfunction

    // Set of slots a mode visits; the auxiliary scan takes its enables.
    function automatic logic [NUM_SLOTS-1:0] slot_mask(input logic [MODE_W-1:0] mode,
                                                       input logic [AUX_N-1:0] aux);
        logic [NUM_SLOTS-1:0] m;
        case (mode)
            MODE_XY:   m = 4'b0011;
            MODE_XYZZ: m = 4'b1111;
            MODE_ZZ:   m = 4'b0011;
            MODE_AUTO: m = {1'b0, aux};
            MODE_PORT: m = 4'b0111;
            default:   m = 4'b0000;
        endcase
        return m;
    endfunction

    // Class tag: second member of each pair and the odd auxiliaries.
    function automatic logic chan_tag(input chan_e ch);
        logic t;
        case (ch)
            CH_Y, CH_Z2, CH_AUX1, CH_TEMP: t = 1'b1;
            default:                       t = 1'b0;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/scan_order_map.sv
// Order map: translates the latched mode and slot pointer into the channel
// code, and the requested mode plus enables into the set of slots to visit.
// Assumes mode codes outside the defined set mean an empty scan.
module scan_order_map
    import scan_seq_pkg::*;
(
    input  logic [MODE_W-1:0]     cur_mode_i,
    input  logic [SLOT_IDX_W-1:0] cur_slot_i,
    input  logic [MODE_W-1:0]     req_mode_i,
    input  logic [AUX_N-1:0]      req_aux_i,
    output chan_e                 cur_chan_o,
    output logic [NUM_SLOTS-1:0]  req_mask_o
);
    // Purely combinational lookups into the package ordering rules.
    always_comb begin
        cur_chan_o = slot_chan(cur_mode_i, cur_slot_i);
        req_mask_o = slot_mask(req_mode_i, req_aux_i);
    end
endmodule

// File: rtl/scan_slot_picker.sv
// Slot picker: finds the lowest set bit of a slot mask, which gives the
// next channel in sequence order. Assumes lower slots convert first.
module scan_slot_picker #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Priority search, scanning down so the lowest set bit wins.
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/scan_avail_flags.sv
// Sticky availability flags: each flag sets on its strobe and clears on a
// shared read strobe; a set on the same edge as a clear wins.
module scan_avail_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky bit: set has priority over the read clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         flag_o[g] <= 1'b0;
            else if (set_i[g])  flag_o[g] <= 1'b1;
            else if (clr_i)     flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/scan_sequencer.sv
// Conversion scan sequencer top. On an accepted start it latches the mode
// and the set of slots to visit, then issues one convert-start per slot and
// waits for the converter's done strobe. Each done produces one tagged
// result. Assumes the converter never reports done in the cycle its start
// strobe is high; such a strobe is ignored.
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] scan_mode_i,
    input  logic [AUX_N-1:0]  aux_en_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              status_rd_i,
    output logic [CHAN_W-1:0] chan_sel_o,
    output logic              conv_start_o,
    output logic              res_valid_o,
    output logic              res_id_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              busy_o,
    output logic              x_avail_o,
    output logic              y_avail_o
);
    localparam int FLAG_N = 2;

    logic                  busy_q;
    logic                  start_q;
    logic                  valid_q;
    logic                  tag_q;
    logic [DATA_W-1:0]     data_q;
    logic [MODE_W-1:0]     mode_q;
    logic [NUM_SLOTS-1:0]  left_q;
    logic [SLOT_IDX_W-1:0] slot_q;

    chan_e                 cur_chan;
    logic [NUM_SLOTS-1:0]  req_mask;
    logic [NUM_SLOTS-1:0]  rest_mask;
    logic [NUM_SLOTS-1:0]  pick_in;
    logic                  pick_any;
    logic [SLOT_IDX_W-1:0] pick_idx;
    logic                  take_start;
    logic                  take_done;
    logic [FLAG_N-1:0]     flag_set;
    logic [FLAG_N-1:0]     flags;

    scan_order_map u_map (
        .cur_mode_i (mode_q),
        .cur_slot_i (slot_q),
        .req_mode_i (scan_mode_i),
        .req_aux_i  (aux_en_i),
        .cur_chan_o (cur_chan),
        .req_mask_o (req_mask)
    );

    // Accept qualifiers and the mask left after the current slot.
    always_comb begin
        take_start = start_i && !busy_q;
        take_done  = conv_done_i && busy_q && !start_q;
        rest_mask  = left_q & ~(NUM_SLOTS'(1) << slot_q);
        pick_in    = busy_q ? rest_mask : req_mask;
    end

    scan_slot_picker #(.N(NUM_SLOTS)) u_pick (
        .pend_i (pick_in),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    // Scan control: latch on start, advance or finish on each done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            valid_q <= 1'b0;
            tag_q   <= 1'b0;
            data_q  <= '0;
            mode_q  <= MODE_XY;
            left_q  <= '0;
            slot_q  <= '0;
        end else begin
            start_q <= 1'b0;
            valid_q <= 1'b0;
            if (take_start) begin
                mode_q <= scan_mode_i;
                left_q <= req_mask;
                if (pick_any) begin
                    busy_q  <= 1'b1;
                    slot_q  <= pick_idx;
                    start_q <= 1'b1;
                end
            end else if (take_done) begin
                valid_q <= 1'b1;
                data_q  <= conv_data_i;
                tag_q   <= chan_tag(cur_chan);
                left_q  <= rest_mask;
                if (pick_any) begin
                    slot_q  <= pick_idx;
                    start_q <= 1'b1;
                end else begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // Flag set strobes: bit 0 for an X result, bit 1 for a Y result.
    always_comb begin
        flag_set[0] = take_done && (cur_chan == CH_X);
        flag_set[1] = take_done && (cur_chan == CH_Y);
    end

    scan_avail_flags #(.N(FLAG_N)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (status_rd_i),
        .flag_o (flags)
    );

    // Output wiring.
    always_comb begin
        chan_sel_o   = cur_chan;
        conv_start_o = start_q;
        res_valid_o  = valid_q;
        res_id_o     = tag_q;
        res_data_o   = data_q;
        busy_o       = busy_q;
        x_avail_o    = flags[0];
        y_avail_o    = flags[1];
    end
endmodule

// File: rtl/scan_sequencer_checker.sv
// Protocol checker for the scan sequencer, attached by bind below.
// Observes only the top-level ports.
module scan_sequencer_checker (
    input logic clk,
    input logic rst_n,
    input logic conv_done_i,
    input logic busy_o,
    input logic conv_start_o,
    input logic res_valid_o,
    input logic res_id_o,
    input logic x_avail_o,
    input logic y_avail_o
);
    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    assert_start_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> busy_o);

    assert_busy_fall_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> res_valid_o);

    assert_done_gives_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && busy_o && !conv_start_o) |=> res_valid_o);

    assert_no_spurious_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_done_i && busy_o && !conv_start_o) |=> !res_valid_o);

    assert_no_start_while_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !conv_done_i) |=> !conv_start_o);

    assert_x_flag_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_avail_o) |-> (res_valid_o && !res_id_o));

    assert_y_flag_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_avail_o) |-> (res_valid_o && res_id_o));
endmodule

bind scan_sequencer scan_sequencer_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done_i  (conv_done_i),
    .busy_o       (busy_o),
    .conv_start_o (conv_start_o),
    .res_valid_o  (res_valid_o),
    .res_id_o     (res_id_o),
    .x_avail_o    (x_avail_o),
    .y_avail_o    (y_avail_o)
);

// File: tb/scan_sequencer_bench.sv
// Bench for the scan sequencer: directed scans per mode plus seeded random
// scans, with a converter model that answers after a random latency.
module scan_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  scan_mode_i = 3'd0;
    logic [2:0]  aux_en_i = 3'd0;
    logic        conv_done_i = 1'b0;
    logic [11:0] conv_data_i = 12'd0;
    logic        status_rd_i = 1'b0;
    logic [2:0]  chan_sel_o;
    logic        conv_start_o;
    logic        res_valid_o;
    logic        res_id_o;
    logic [11:0] res_data_o;
    logic        busy_o;
    logic        x_avail_o;
    logic        y_avail_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit xm = 1'b0;
    bit ym = 1'b0;

    always #4 clk = ~clk;

    scan_sequencer u_scan_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .scan_mode_i  (scan_mode_i),
        .aux_en_i     (aux_en_i),
        .conv_done_i  (conv_done_i),
        .conv_data_i  (conv_data_i),
        .status_rd_i  (status_rd_i),
        .chan_sel_o   (chan_sel_o),
        .conv_start_o (conv_start_o),
        .res_valid_o  (res_valid_o),
        .res_id_o     (res_id_o),
        .res_data_o   (res_data_o),
        .busy_o       (busy_o),
        .x_avail_o    (x_avail_o),
        .y_avail_o    (y_avail_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected channel list from the requirement text; returns its length.
    function automatic int exp_seq(input int mode, input logic [2:0] aux,
                                   output logic [3:0][2:0] s);
        int n = 0;
        s = '0;
        case (mode)
            0: begin s[0] = 3'd1; s[1] = 3'd0; n = 2; end
            1: begin s[0] = 3'd1; s[1] = 3'd0; s[2] = 3'd2; s[3] = 3'd3; n = 4; end
            2: begin s[0] = 3'd2; s[1] = 3'd3; n = 2; end
            3: begin
                if (aux[0]) begin s[n] = 3'd5; n++; end
                if (aux[1]) begin s[n] = 3'd6; n++; end
                if (aux[2]) begin s[n] = 3'd7; n++; end
            end
            4: begin s[0] = 3'd4; s[1] = 3'd5; s[2] = 3'd6; n = 3; end
            default: n = 0;
        endcase
        return n;
    endfunction

    function automatic bit exp_id(input logic [2:0] ch);
        return (ch == 3'd1) || (ch == 3'd3) || (ch == 3'd5) || (ch == 3'd7);
    endfunction

    task automatic run_scan(input int mode, input logic [2:0] aux,
                            input bit poke, input bit collide);
        logic [3:0][2:0] s;
        logic [11:0] d;
        int n;
        int lat;
        string oreq;
        n = exp_seq(mode, aux, s);
        oreq = (mode == 3) ? "R1/R3" : (mode == 4) ? "R1/R4" : "R1/R2";
        @(negedge clk);
        start_i = 1'b1; scan_mode_i = mode[2:0]; aux_en_i = aux;
        @(negedge clk);
        start_i = 1'b0; scan_mode_i = 3'($urandom); aux_en_i = 3'($urandom);
        if (n == 0) begin
            chk(!busy_o && !conv_start_o, "R4 empty scan", int'(busy_o), 0);
            @(negedge clk);
            chk(!busy_o && !conv_start_o, "R4 empty scan stays idle", int'(conv_start_o), 0);
            return;
        end
        chk(busy_o, "R7 busy after start", int'(busy_o), 1);
        for (int k = 0; k < n; k++) begin
            chk(conv_start_o, "R7 convert-start", int'(conv_start_o), 1);
            chk(chan_sel_o == s[k], oreq, int'(chan_sel_o), int'(s[k]));
            lat = 1 + int'($urandom % 3);
            for (int i = 0; i < lat; i++) begin
                start_i = poke && (i == 0);
                @(negedge clk);
                start_i = 1'b0;
                chk(!conv_start_o && busy_o, "R8 no restart while busy",
                    int'(conv_start_o), 0);
                chk(!res_valid_o, "R6 single-cycle valid", int'(res_valid_o), 0);
            end
            d = 12'($urandom);
            conv_done_i = 1'b1; conv_data_i = d; status_rd_i = collide;
            @(negedge clk);
            conv_done_i = 1'b0; status_rd_i = 1'b0;
            if (collide) begin xm = 1'b0; ym = 1'b0; end
            if (s[k] == 3'd0) xm = 1'b1;
            if (s[k] == 3'd1) ym = 1'b1;
            chk(res_valid_o, "R6 result valid", int'(res_valid_o), 1);
            chk(res_data_o == d, "R6 result data", int'(res_data_o), int'(d));
            chk(res_id_o == exp_id(s[k]), "R5 tag", int'(res_id_o), int'(exp_id(s[k])));
            chk(x_avail_o == xm, "R9 x flag", int'(x_avail_o), int'(xm));
            chk(y_avail_o == ym, "R9 y flag", int'(y_avail_o), int'(ym));
            if (k == n - 1)
                chk(!busy_o && !conv_start_o, "R7 end of scan", int'(busy_o), 0);
        end
        @(negedge clk);
        chk(!res_valid_o && !conv_start_o, "R6 valid dropped", int'(res_valid_o), 0);
    endtask

    task automatic status_read();
        @(negedge clk);
        status_rd_i = 1'b1;
        @(negedge clk);
        status_rd_i = 1'b0;
        xm = 1'b0; ym = 1'b0;
        chk(!x_avail_o && !y_avail_o, "R9 flags cleared by read",
            int'({y_avail_o, x_avail_o}), 0);
    endtask

    task automatic idle_done();
        @(negedge clk);
        conv_done_i = 1'b1; conv_data_i = 12'hABC;
        @(negedge clk);
        conv_done_i = 1'b0;
        chk(!res_valid_o && !busy_o, "R6 idle done ignored", int'(res_valid_o), 0);
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !conv_start_o && !res_valid_o && !x_avail_o && !y_avail_o,
            "R7 reset state",
            int'({busy_o, conv_start_o, res_valid_o, x_avail_o, y_avail_o}), 0);
        run_scan(0, 3'b000, 1'b0, 1'b0);
        chk(x_avail_o && y_avail_o, "R9 flags held after scan",
            int'({y_avail_o, x_avail_o}), 3);
        status_read();
        run_scan(1, 3'b000, 1'b1, 1'b0);
        run_scan(2, 3'b000, 1'b0, 1'b0);
        run_scan(3, 3'b111, 1'b0, 1'b0);
        run_scan(3, 3'b101, 1'b1, 1'b0);
        run_scan(3, 3'b010, 1'b0, 1'b0);
        run_scan(3, 3'b000, 1'b0, 1'b0);
        run_scan(4, 3'b000, 1'b0, 1'b0);
        run_scan(5, 3'b111, 1'b0, 1'b0);
        run_scan(7, 3'b000, 1'b0, 1'b0);
        idle_done();
        status_read();
        run_scan(0, 3'b000, 1'b0, 1'b1);
        run_scan(1, 3'b000, 1'b1, 1'b1);
        for (int r = 0; r < 60; r++) begin
            run_scan(int'($urandom % 8), 3'($urandom), bit'($urandom % 2),
                     ($urandom % 4) == 0);
            if (($urandom % 5) == 0) status_read();
            if (($urandom % 7) == 0) idle_done();
        end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule